// File: doc/BRIEF.md
# Keyed Application Reset Control Register

This block is a single 32-bit memory-mapped control register in a processor system. It holds a handful of configuration fields and turns two of its bits into action pulses. These pulses are a system reset request and a command that clears active exception state. Any write that does not carry the correct unlock value in its upper halfword is discarded as a whole. A read always shows a different, fixed key value in that same halfword.

Software or a debugger writes the register over a simple register bus. The bus carries a flag that marks the access as secure or non-secure. A secure writer may lock the reset request so that only secure writers can use it. Non-secure writers may change only the priority-grouping field. The clear-active command is honoured only when the core is halted with debug enabled. The byte-order bit is a strap input that the register reports but never stores.

Top module: `keyed_rst_ctl`

## Requirements
- R1: A write to the register address takes effect only if wdata[31:16] equals 0x05FA. Any other key leaves every field unchanged and produces no pulse.
- R2: When addr selects the register, rdata[31:16] reads 0xFA05 and rdata[15] reflects the endian strap input (1 = big-endian). Bits 12:11, 7:4, 2, 1 and 0 read as 0. When addr selects any other location, rdata is all zero.
- R3: Field layout is: bit 14 = non-secure de-prioritise, bit 13 = fault/NMI to non-secure, bits 10:8 = priority-grouping point, bit 3 = reset-request secure-only lock. All four fields reset to 0.
- R4: A keyed write with wdata[2]=1 that is permitted drives sys_rst_req high for exactly one cycle. The pulse follows the clock edge that captures the write.
- R5: When the stored lock bit 3 is 1, a non-secure reset request is dropped and a secure one is honoured. When the lock is 0, requests from both states are honoured. The lock value in force is the one held before the write.
- R6: A keyed write with wdata[1]=1 drives clr_active high for one cycle only if core_halted and dbg_en are both 1 at the write. Otherwise it gives no pulse.
- R7: A non-secure keyed write updates bits 10:8 but leaves bits 14, 13 and 3 unchanged. A secure keyed write updates all four fields.
- R8: A write with wr_en=1 to an address other than the register address changes nothing and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | ADDR_W (12) | Word address of the access |
| wdata | input | 32 | Write data |
| secure_acc | input | 1 | 1 = access comes from the secure state |
| core_halted | input | 1 | Core is halted in debug state |
| dbg_en | input | 1 | Halting debug is enabled |
| endian_strap | input | 1 | Byte-order strap, 1 = big-endian |
| rdata | output | 32 | Read data, combinational from addr |
| sys_rst_req | output | 1 | One-cycle system reset request |
| clr_active | output | 1 | One-cycle clear-active-state command |

## Verification
Read data is combinational, so the bench compares rdata a moment after it sets addr, with no clock edge in between. Stored fields and both pulses change at the edge that captures a keyed write. The bench therefore samples the pulses one time unit after that edge and expects them high in that cycle only. It then samples again after the following edge and expects both pulses low. Field state is read back through rdata after each write, so a write that should be dropped is seen to have left every field at its earlier value.

// File: rtl/keyed_rst_pkg.sv
package keyed_rst_pkg;

    localparam int          DATA_W    = 32;
    localparam int          KEY_W     = 16;
    localparam logic [15:0] WR_KEY    = 16'h05FA;
    localparam logic [15:0] RD_KEY    = 16'hFA05;
    localparam int          GRP_W     = 3;

    // bit positions the consumers of this register decode
    localparam int BIT_NS_DEPRI = 14;
    localparam int BIT_NS_FAULT = 13;
    localparam int GRP_LSB      = 8;
    localparam int BIT_RST_LOCK = 3;
    localparam int BIT_RST_REQ  = 2;
    localparam int BIT_CLR_ACT  = 1;

    typedef struct packed {
        logic             ns_depri;
        logic             ns_fault;
        logic             rst_lock;
        logic [GRP_W-1:0] grp_point;
    } ctl_fields_t;

    localparam ctl_fields_t FIELDS_RST = '0;

    function automatic logic [DATA_W-1:0] pack_read(input ctl_fields_t f, input logic endian);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1 -: KEY_W]            = RD_KEY;
        w[15]                           = endian;
        w[BIT_NS_DEPRI]                 = f.ns_depri;
        w[BIT_NS_FAULT]                 = f.ns_fault;
        w[GRP_LSB +: GRP_W]             = f.grp_point;
        w[BIT_RST_LOCK]                 = f.rst_lock;
        return w;
    endfunction

endpackage

// File: rtl/keyed_rst_gate.sv
module keyed_rst_gate
    import keyed_rst_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'hD0C
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              secure_acc,
    input  logic              core_halted,
    input  logic              dbg_en,
    input  ctl_fields_t       cur,
    output logic              upd_en,
    output ctl_fields_t       nxt,
    output logic [1:0]        fire
);

    logic key_ok;
    logic unused_rsvd;

    assign key_ok      = wdata[DATA_W-1 -: KEY_W] == WR_KEY;
    assign upd_en      = wr_en && (addr == REG_ADDR) && key_ok;
    assign unused_rsvd = ^{wdata[15], wdata[12:11], wdata[7:4], wdata[0]};

    always_comb begin
        nxt           = cur;
        nxt.grp_point = wdata[GRP_LSB +: GRP_W];
        if (secure_acc) begin
            nxt.ns_depri = wdata[BIT_NS_DEPRI];
            nxt.ns_fault = wdata[BIT_NS_FAULT];
            nxt.rst_lock = wdata[BIT_RST_LOCK];
        end
    end

    // fire[0]: reset request, fire[1]: clear active
    assign fire[0] = upd_en && wdata[BIT_RST_REQ] && (secure_acc || !cur.rst_lock);
    assign fire[1] = upd_en && wdata[BIT_CLR_ACT] && core_halted && dbg_en;

endmodule

// File: rtl/keyed_rst_store.sv
module keyed_rst_store
    import keyed_rst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        upd_en,
    input  ctl_fields_t nxt,
    output ctl_fields_t q
);

    always_ff @(posedge clk) begin
        if (rst)         q <= FIELDS_RST;
        else if (upd_en) q <= nxt;
    end

    // R1: fields hold when no accepted write
    p_hold_unkeyed_r1: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(q));

endmodule

// File: rtl/keyed_rst_pulse.sv
module keyed_rst_pulse #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] fire,
    output logic [N-1:0] pulse
);

    for (genvar i = 0; i < N; i++) begin : g_pulse
        always_ff @(posedge clk) begin
            if (rst) pulse[i] <= 1'b0;
            else     pulse[i] <= fire[i];
        end
    end

endmodule

// File: rtl/keyed_rst_ctl.sv
module keyed_rst_ctl
    import keyed_rst_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'hD0C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              secure_acc,
    input  logic              core_halted,
    input  logic              dbg_en,
    input  logic              endian_strap,
    output logic [31:0]       rdata,
    output logic              sys_rst_req,
    output logic              clr_active
);

    localparam int NPULSE = 2;

    ctl_fields_t       cur_q;
    ctl_fields_t       nxt_d;
    logic              upd_en;
    logic [NPULSE-1:0] fire;
    logic [NPULSE-1:0] pulse_q;

    keyed_rst_gate #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_gate (
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .secure_acc  (secure_acc),
        .core_halted (core_halted),
        .dbg_en      (dbg_en),
        .cur         (cur_q),
        .upd_en      (upd_en),
        .nxt         (nxt_d),
        .fire        (fire)
    );

    keyed_rst_store u_store (
        .clk    (clk),
        .rst    (rst),
        .upd_en (upd_en),
        .nxt    (nxt_d),
        .q      (cur_q)
    );

    keyed_rst_pulse #(.N(NPULSE)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .pulse (pulse_q)
    );

    assign sys_rst_req = pulse_q[0];
    assign clr_active  = pulse_q[1];
    assign rdata       = (addr == REG_ADDR) ? pack_read(cur_q, endian_strap) : '0;

    // R4: a reset pulse needs a keyed write to this register asking for it
    p_rst_keyed_r4: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> $past(wr_en && addr == REG_ADDR
                              && wdata[31:16] == WR_KEY && wdata[BIT_RST_REQ]));

    // R5: locked reset request only from a secure writer
    p_rst_lock_r5: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> $past(secure_acc || !cur_q.rst_lock));

    // R6: clear-active only while halted with debug enabled
    p_clr_halted_r6: assert property (@(posedge clk) disable iff (rst)
        clr_active |-> $past(core_halted && dbg_en));

    // R7: non-secure writes never touch the secure-owned bits
    p_ns_protect_r7: assert property (@(posedge clk) disable iff (rst)
        !secure_acc |=> $stable({cur_q.ns_depri, cur_q.ns_fault, cur_q.rst_lock}));

    // R8: writes elsewhere leave the fields alone
    p_other_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (addr != REG_ADDR) |=> $stable(cur_q));

endmodule

// File: tb/keyed_rst_ctl_tb_top.sv
module keyed_rst_ctl_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          MAX_CYC    = 20000;
    localparam logic [11:0] RADDR      = 12'hD0C;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        secure_acc, core_halted, dbg_en, endian_strap;
    logic [31:0] rdata;
    logic        sys_rst_req, clr_active;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // bench model of the stored fields
    logic       m_depri, m_fault, m_lock;
    logic [2:0] m_grp;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_rst_ctl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .secure_acc(secure_acc), .core_halted(core_halted), .dbg_en(dbg_en),
        .endian_strap(endian_strap), .rdata(rdata),
        .sys_rst_req(sys_rst_req), .clr_active(clr_active)
    );

    function automatic logic [31:0] exp_word(input logic strap);
        return {16'hFA05, strap, m_depri, m_fault, 2'b00, m_grp, 4'b0000, m_lock, 3'b000};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_read(input string req);
        addr = RADDR;
        #1;
        check(req, rdata, exp_word(endian_strap));
    endtask

    // one write, checks both pulses and the readback afterwards
    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic sec,
                            input logic hlt, input logic dbg);
        logic hit, e_rst, e_clr;
        hit   = (a == RADDR) && (d[31:16] == 16'h05FA);
        e_rst = hit && d[2] && (sec || !m_lock);
        e_clr = hit && d[1] && hlt && dbg;
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; secure_acc = sec; core_halted = hlt; dbg_en = dbg;
        @(posedge clk);
        #1;
        if (hit) begin
            m_grp = d[10:8];
            if (sec) begin
                m_depri = d[14]; m_fault = d[13]; m_lock = d[3];
            end
        end
        check("R4/R5 sys_rst_req", {31'b0, sys_rst_req}, {31'b0, e_rst});
        check("R6 clr_active", {31'b0, clr_active}, {31'b0, e_clr});
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        check("R4 one-cycle pulse", {30'b0, sys_rst_req, clr_active}, 32'b0);
        check_read(hit ? "R1/R3/R7 readback" : "R1/R8 dropped write readback");
    endtask

    initial begin
        while (cyc < MAX_CYC) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, MAX_CYC);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        rst = 1'b1; wr_en = 1'b0; addr = RADDR; wdata = '0;
        secure_acc = 1'b0; core_halted = 1'b0; dbg_en = 1'b0; endian_strap = 1'b0;
        m_depri = 1'b0; m_fault = 1'b0; m_lock = 1'b0; m_grp = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R3 reset readback", rdata, 32'hFA05_0000);
        check("R4 reset pulses", {30'b0, sys_rst_req, clr_active}, 32'b0);
        @(negedge clk);
        rst = 1'b0;

        // R2: strap reflected, other address reads zero
        endian_strap = 1'b1;
        check_read("R2 strap big-endian");
        addr = 12'hD10; #1;
        check("R2 other address reads zero", rdata, 32'b0);

        // R3/R7: secure write of all fields, reserved and pulse bits read 0
        do_write(RADDR, 32'h05FA_7FFF & ~32'h0000_0006, 1'b1, 1'b0, 1'b0);
        // R1: bad key dropped
        do_write(RADDR, 32'h05FB_0000, 1'b1, 1'b0, 1'b0);
        do_write(RADDR, 32'hFA05_0004, 1'b1, 1'b1, 1'b1);
        // R7: non-secure tries clearing secure bits
        do_write(RADDR, 32'h05FA_0200, 1'b0, 1'b0, 1'b0);
        // R5: locked, non-secure request dropped, secure honoured
        do_write(RADDR, 32'h05FA_0004, 1'b0, 1'b0, 1'b0);
        do_write(RADDR, 32'h05FA_000C, 1'b1, 1'b0, 1'b0);
        // R5: unlock then non-secure request honoured
        do_write(RADDR, 32'h05FA_0000, 1'b1, 1'b0, 1'b0);
        do_write(RADDR, 32'h05FA_0004, 1'b0, 1'b0, 1'b0);
        // R6: clear-active gating
        do_write(RADDR, 32'h05FA_0002, 1'b1, 1'b1, 1'b0);
        do_write(RADDR, 32'h05FA_0002, 1'b1, 1'b0, 1'b1);
        do_write(RADDR, 32'h05FA_0002, 1'b0, 1'b1, 1'b1);
        // R8: right key, wrong address
        do_write(12'hD08, 32'h05FA_6F0E, 1'b1, 1'b1, 1'b1);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] d;
            logic [11:0] a;
            d = $urandom;
            if ($urandom_range(0, 3) != 0) d[31:16] = 16'h05FA;
            a = ($urandom_range(0, 7) == 0) ? 12'($urandom) : RADDR;
            endian_strap = 1'($urandom);
            do_write(a, d, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule